// File: doc/BRIEF.md
# Hub Status Change Interrupt Endpoint

This block holds the status-change bitmap of a USB hub and answers IN tokens that target the hub's interrupt endpoint. Change events come in as single-cycle pulses, one for the hub itself and one for each downstream port. Each event is first held in a per-bit pending stage. Once per frame, on the late end-of-frame sample strobe, the pending bits are moved into the reported bitmap. A bit in the reported bitmap stays set until the host clears it with a clear-feature request, so the host sees the change on every poll until then.

When an IN token arrives, the block chooses one of three handshakes and registers it, together with the byte to send, on the next clock edge. It answers STALL while the endpoint is halted. It answers NAK while the hub is unconfigured or while the reported bitmap is empty. Otherwise it sends the whole bitmap byte as data. Packet encoding, CRC generation and the control endpoint belong to neighbouring blocks.

Top module: `hsc_intr_ep`

## Requirements
- R1: The reported bitmap changes only on the clock edge ending a cycle in which `eof_sample_i` is high, except for host clears. Events seen before that edge accumulate in the pending stage and appear in the report together.
- R2: Bitmap layout: bit 0 is the hub-level change, bit i (1..NUM_PORTS) is port i's change (`port_chg_i[i-1]`, `clr_chg_i[i]`), and bits above NUM_PORTS always read as zero.
- R3: A token that meets an empty reported bitmap, with the hub configured and the endpoint not stalled, is answered with kind NAK (2'b00) and data 0x00.
- R4: A token that meets a non-empty reported bitmap, with the hub configured and the endpoint not stalled, is answered with kind DATA (2'b01) and the whole bitmap byte.
- R5: A reported bit stays set over any number of polls until `clr_chg_i` is high for that bit. A clear also drops that bit from the pending stage, so a clear in the same cycle as a sample strobe leaves the bit unreported. An event in the same cycle as a clear of its bit stays pending.
- R6: While `configured_i` is low, every token is answered NAK with data 0x00, whatever the bitmap holds. Changes captured meanwhile are kept and are reported once the hub is configured.
- R7: While `ep_stall_i` is high, every token is answered with kind STALL (2'b10) and data 0x00. This takes precedence over both the configured state and the bitmap.
- R8: An event that arrives in the same cycle as the sample strobe, or later, is reported only at the next strobe.
- R9: `rsp_valid_o` is high for exactly the one cycle that follows a cycle with `in_tok_i` high, and is low otherwise. The response reflects the bitmap as it stood in the token cycle, before any update on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hub_chg_i | input | 1 | Hub-level change event pulse |
| port_chg_i | input | NUM_PORTS | Per-port change event pulses, bit i-1 for port i |
| eof_sample_i | input | 1 | Late end-of-frame sample strobe |
| configured_i | input | 1 | Hub has been configured by the host |
| ep_stall_i | input | 1 | Interrupt endpoint is halted |
| in_tok_i | input | 1 | IN token addressed to this endpoint |
| clr_chg_i | input | NUM_PORTS+1 | Clear-feature pulses, bit 0 hub, bit i port i |
| rsp_valid_o | output | 1 | Handshake decision is valid this cycle |
| rsp_kind_o | output | 2 | 00 NAK, 01 DATA, 10 STALL |
| rsp_data_o | output | DATA_W | Bitmap byte for DATA, zero otherwise |

## Verification
Every one of the 32 combinations of the five change bits is injected, polled once before the sample strobe and twice after it, and then cleared. This shows that the sample moves exactly the injected pattern, that nothing leaks out early, and that bits persist across polls. Clearing one bit at a time out of a full map shows that each clear line maps to its own bit position. Directed cases line up an event, a clear or a token with the sample strobe in the same cycle, which separates the intended edge ordering from its neighbours. Polls under unconfigured and stalled conditions, with empty and with full maps, check the handshake priority.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   typedef enum logic [1:0] {
      RSP_NAK   = 2'b00,
      RSP_DATA  = 2'b01,
      RSP_STALL = 2'b10
   } rsp_kind_e;
endpackage

// File: rtl/hsc_change_bit.sv
// One change bit: a pending stage that collects events and a sticky
// reported stage loaded at the frame sample strobe.
module hsc_change_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   input  logic sample_i,
   output logic rep_o
);
   logic pend_q;
   logic rep_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rep_q  <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr_i & ~sample_i) | evt_i;
         rep_q  <= (rep_q & ~clr_i) | (sample_i & pend_q & ~clr_i);
      end
   end

   assign rep_o = rep_q;
endmodule

// File: rtl/hsc_change_map.sv
// Full bitmap: live cells for the hub and each port, constant zero above.
module hsc_change_map #(
   parameter int NUM_BITS = 5,
   parameter int DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_BITS-1:0] evt_i,
   input  logic [NUM_BITS-1:0] clr_i,
   input  logic                sample_i,
   output logic [DATA_W-1:0]   map_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < NUM_BITS) begin : g_live
         hsc_change_bit u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[b]),
            .clr_i    (clr_i[b]),
            .sample_i (sample_i),
            .rep_o    (map_o[b])
         );
      end else begin : g_resv
         assign map_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/hsc_responder.sv
// Handshake decision, registered one cycle after the token.
module hsc_responder #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] map_i,
   input  logic              in_tok_i,
   input  logic              stall_i,
   input  logic              cfg_i,
   output logic              valid_o,
   output hsc_pkg::rsp_kind_e kind_o,
   output logic [DATA_W-1:0] data_o
);
   import hsc_pkg::*;

   rsp_kind_e         kind_d;
   logic [DATA_W-1:0] data_d;

   always_comb begin
      kind_d = RSP_NAK;
      data_d = '0;
      if (stall_i) begin
         kind_d = RSP_STALL;
      end else if (cfg_i && (|map_i)) begin
         kind_d = RSP_DATA;
         data_d = map_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         kind_o  <= RSP_NAK;
         data_o  <= '0;
      end else begin
         valid_o <= in_tok_i;
         kind_o  <= in_tok_i ? kind_d : RSP_NAK;
         data_o  <= in_tok_i ? data_d : '0;
      end
   end
endmodule

// File: rtl/hsc_intr_ep.sv
module hsc_intr_ep #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hub_chg_i,
   input  logic [NUM_PORTS-1:0] port_chg_i,
   input  logic                 eof_sample_i,
   input  logic                 configured_i,
   input  logic                 ep_stall_i,
   input  logic                 in_tok_i,
   input  logic [NUM_PORTS:0]   clr_chg_i,
   output logic                 rsp_valid_o,
   output logic [1:0]           rsp_kind_o,
   output logic [DATA_W-1:0]    rsp_data_o
);
   localparam int NUM_BITS = NUM_PORTS + 1;

   if (NUM_PORTS < 1 || NUM_BITS > DATA_W) begin : g_bad_cfg
      $error("hsc_intr_ep: NUM_PORTS+1 must fit in DATA_W and be at least 2");
   end

   logic [NUM_BITS-1:0] evt_w;
   logic [DATA_W-1:0]   report_q;
   hsc_pkg::rsp_kind_e  kind_w;

   assign evt_w = {port_chg_i, hub_chg_i};

   hsc_change_map #(.NUM_BITS(NUM_BITS), .DATA_W(DATA_W)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_w),
      .clr_i    (clr_chg_i),
      .sample_i (eof_sample_i),
      .map_o    (report_q)
   );

   hsc_responder #(.DATA_W(DATA_W)) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .map_i    (report_q),
      .in_tok_i (in_tok_i),
      .stall_i  (ep_stall_i),
      .cfg_i    (configured_i),
      .valid_o  (rsp_valid_o),
      .kind_o   (kind_w),
      .data_o   (rsp_data_o)
   );

   assign rsp_kind_o = kind_w;
endmodule

// File: rtl/hsc_intr_ep_chk.sv
module hsc_intr_ep_chk #(
   parameter int NUM_PORTS = 4,
   parameter int DATA_W    = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               eof_sample_i,
   input logic               configured_i,
   input logic               ep_stall_i,
   input logic               in_tok_i,
   input logic [NUM_PORTS:0] clr_chg_i,
   input logic               rsp_valid_o,
   input logic [1:0]         rsp_kind_o,
   input logic [DATA_W-1:0]  rsp_data_o,
   input logic [DATA_W-1:0]  report
);
   import hsc_pkg::*;
   localparam int NUM_BITS = NUM_PORTS + 1;
   localparam logic [DATA_W-1:0] RESV_MASK = {DATA_W{1'b1}} << NUM_BITS;

   logic [DATA_W-1:0] clr_ext;
   logic [DATA_W-1:0] keep;
   assign clr_ext = DATA_W'(clr_chg_i);
   assign keep    = report & ~clr_ext;

   assert_no_new_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_sample_i |=> ((report & ~$past(report)) == '0));

   assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> ((rsp_data_o & RESV_MASK) == '0));

   assert_empty_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && !ep_stall_i && configured_i && report == '0)
      |=> (rsp_kind_o == RSP_NAK && rsp_data_o == '0));

   assert_nondata_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_kind_o != RSP_DATA) |-> (rsp_data_o == '0));

   assert_full_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && !ep_stall_i && configured_i && report != '0)
      |=> (rsp_kind_o == RSP_DATA && rsp_data_o == $past(report)));

   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((report & $past(keep)) == $past(keep)));

   assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_sample_i |=> ((report & $past(clr_ext)) == '0));

   assert_unconfigured_nak_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && !ep_stall_i && !configured_i) |=> (rsp_kind_o == RSP_NAK));

   assert_stall_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_tok_i && ep_stall_i) |=> (rsp_kind_o == RSP_STALL));

   assert_rsp_follows_tok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_tok_i |=> rsp_valid_o);

   assert_no_rsp_without_tok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_tok_i |=> !rsp_valid_o);
endmodule

bind hsc_intr_ep hsc_intr_ep_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .eof_sample_i (eof_sample_i),
   .configured_i (configured_i),
   .ep_stall_i   (ep_stall_i),
   .in_tok_i     (in_tok_i),
   .clr_chg_i    (clr_chg_i),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_kind_o   (rsp_kind_o),
   .rsp_data_o   (rsp_data_o),
   .report       (report_q)
);

// File: tb/tb_hsc_intr_ep.sv
module tb_hsc_intr_ep;
   localparam int NP = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hub_chg_i = 1'b0;
   logic [NP-1:0] port_chg_i = '0;
   logic          eof_sample_i = 1'b0;
   logic          configured_i = 1'b0;
   logic          ep_stall_i = 1'b0;
   logic          in_tok_i = 1'b0;
   logic [NP:0]   clr_chg_i = '0;
   logic          rsp_valid_o;
   logic [1:0]    rsp_kind_o;
   logic [DW-1:0] rsp_data_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [NP:0] m_pend = '0;
   logic [NP:0] m_rep = '0;

   always #10 clk = ~clk;

   hsc_intr_ep #(.NUM_PORTS(NP), .DATA_W(DW)) dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // One cycle of stimulus; the response of a token is checked at the next negedge.
   task automatic step(input logic [NP:0] e, input bit eof, input logic [NP:0] c,
                       input bit tok, input string tag);
      logic [1:0]    ek;
      logic [DW-1:0] ed;
      hub_chg_i    = e[0];
      port_chg_i   = e[NP:1];
      eof_sample_i = eof;
      clr_chg_i    = c;
      in_tok_i     = tok;
      if (ep_stall_i)               begin ek = 2'b10; ed = '0; end
      else if (!configured_i)       begin ek = 2'b00; ed = '0; end
      else if (m_rep == '0)         begin ek = 2'b00; ed = '0; end
      else                          begin ek = 2'b01; ed = DW'(m_rep); end
      @(negedge clk);
      chk(rsp_valid_o == tok, "R9 valid", int'(rsp_valid_o), int'(tok));
      if (tok) begin
         chk(rsp_kind_o == ek, {tag, " kind"}, int'(rsp_kind_o), int'(ek));
         chk(rsp_data_o == ed, {tag, " data"}, int'(rsp_data_o), int'(ed));
         chk(rsp_data_o[DW-1:NP+1] == '0, "R2 reserved", int'(rsp_data_o), int'(ed));
      end
      m_rep  = (m_rep & ~c) | (eof ? (m_pend & ~c) : '0);
      m_pend = (eof ? '0 : (m_pend & ~c)) | e;
      hub_chg_i = 1'b0; port_chg_i = '0; eof_sample_i = 1'b0;
      clr_chg_i = '0; in_tok_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(rsp_valid_o == 1'b0, "R9 reset valid", int'(rsp_valid_o), 0);
      chk(rsp_data_o == '0, "R3 reset data", int'(rsp_data_o), 0);
      configured_i = 1'b1;
      step('0, 0, '0, 1, "R3 empty after reset");

      // Sweep all bit patterns through inject, sample, poll and clear.
      for (int v = 0; v < 32; v++) begin
         step(5'(v), 0, '0, 0, "R1 inject");
         step('0, 0, '0, 1, "R1 before sample");
         step('0, 1, '0, 0, "R1 sample");
         step('0, 0, '0, 1, "R4 after sample");
         step('0, 0, '0, 1, "R5 sticky repoll");
         step('0, 0, '1, 0, "R5 clear all");
         step('0, 0, '0, 1, "R3 after clear");
      end

      // Accumulation of separate events into one sample.
      step(5'h01, 0, '0, 0, "R1 ev a");
      step(5'h10, 0, '0, 0, "R1 ev b");
      step('0, 1, '0, 0, "R1 sample");
      step('0, 0, '0, 1, "R1 accumulated");
      step('0, 0, '1, 0, "R5 clear");

      // Per-bit clear position.
      for (int k = 0; k <= NP; k++) begin
         step('1, 0, '0, 0, "R2 set all");
         step('0, 1, '0, 0, "R2 sample");
         step('0, 0, 5'(1 << k), 0, "R2 clear one");
         step('0, 0, '0, 1, "R2 position");
         step('0, 0, '1, 0, "R5 clear");
      end

      // Event on the strobe cycle waits for the next strobe.
      step(5'h04, 1, '0, 0, "R8 event on strobe");
      step('0, 0, '0, 1, "R8 not yet");
      step('0, 1, '0, 0, "R8 next sample");
      step('0, 0, '0, 1, "R8 reported");
      step('0, 0, '1, 0, "R5 clear");

      // Clear together with the sample strobe.
      step(5'h02, 0, '0, 0, "R5 inject");
      step('0, 1, 5'h02, 0, "R5 clear on sample");
      step('0, 0, '0, 1, "R5 clear beats sample");
      step('0, 1, '0, 0, "R5 resample");
      step('0, 0, '0, 1, "R5 pending dropped");

      // Event together with a clear of its bit.
      step(5'h08, 0, 5'h08, 0, "R5 event with clear");
      step('0, 1, '0, 0, "R5 sample");
      step('0, 0, '0, 1, "R5 event survives");
      step('0, 0, '1, 0, "R5 clear");

      // Token on the strobe cycle sees the old map.
      step(5'h10, 0, '0, 0, "R9 inject");
      step('0, 1, '0, 1, "R9 token on strobe");
      step('0, 0, '0, 1, "R9 after strobe");
      step('0, 0, '1, 0, "R5 clear");

      // Unconfigured.
      configured_i = 1'b0;
      step('0, 0, '0, 1, "R6 empty unconfigured");
      step(5'h03, 0, '0, 0, "R6 inject");
      step('0, 1, '0, 0, "R6 sample");
      step('0, 0, '0, 1, "R6 full unconfigured");
      configured_i = 1'b1;
      step('0, 0, '0, 1, "R6 kept after configure");

      // Stall.
      ep_stall_i = 1'b1;
      step('0, 0, '0, 1, "R7 stall full map");
      configured_i = 1'b0;
      step('0, 0, '0, 1, "R7 stall unconfigured");
      configured_i = 1'b1;
      step('0, 0, '1, 0, "R5 clear");
      step('0, 0, '0, 1, "R7 stall empty map");
      ep_stall_i = 1'b0;
      step('0, 0, '0, 1, "R3 after stall");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule